// File: doc/BRIEF.md
# Three-Channel Compare-Match Output Timer

This block is a free-running up-counter with three compare channels. Each channel owns one output pin. A programmable action is applied to the pin on every compare match: hold, force low, force high or toggle. The match also sets a sticky per-channel flag. The counter advances by one on each clock where the start bit is set and the count-source enable input is high. Software picks, through a small register write port, whether a match on channel A clears the counter and whether a match on channel A halts counting.

Software prepares a sequence in a fixed order. It writes the compare values and the actions. It writes the initial pin levels, which also loads them onto the pins. It then enables the outputs (active-low enables) and sets the start bit. Software reads progress from the counter value, the match flags and an overflow flag. The overflow flag marks every step out of the all-ones count, whether that step comes from a natural wrap or from a channel-A clear at FFFFh.

Top module: `cmp_timer3`

## Requirements
- R1: The counter advances by exactly one on each rising clock edge where the start bit (control register, address 0, bit 0) is 1 and `cnt_en` is 1. On every other edge the counter and all pin states hold.
- R2: Writes take effect on the clock edge where `wr_en` is 1, and decode `wr_addr` as follows: 0 control, 1 output configuration, 2 actions, 3 flags, 4/5/6 compare values A/B/C, 7 counter load. A counter load takes priority over counting in the same cycle.
- R3: A compare match occurs on a counting edge (R1) where the counter equals a channel's compare value. On that same edge the channel's pin takes its action. The action field of channel n is at address 2, bits [2n+1:2n], with n = 0, 1, 2 for A, B, C. The codes are 00 hold, 01 low, 10 high and 11 toggle.
- R4: Address 1, bits [2:0], holds the initial levels for A, B and C, where 0 means low and 1 means high. A write to address 1 loads these levels into the pin states. The loaded levels stay on the pins until a match acts on them. Such a write wins over a match in the same cycle.
- R5: Address 1, bits [5:3], holds the active-low output enables for A, B and C. An enable bit of 1 drives that pin to 0. An enable bit of 0 drives the pin with its state.
- R6: `match_flag[n]` is set by a match on channel n and stays set. Writing address 3 with bit n = 0 clears it, and with bit n = 1 has no effect. A match in the same cycle as a clearing write leaves the flag set.
- R7: The control register field at bits [4:2] selects the clear source. With 001, a match on channel A loads 0000h instead of incrementing. Any other value leaves the counter free-running.
- R8: `ovf_flag` is set on any counting edge where the counter is FFFFh. This covers both the natural wrap to 0000h and a clear from FFFFh. It is cleared by writing 0 to address 3, bit 3.
- R9: Control register bit 1 is the keep-running bit. When it is 0, a match on channel A clears the start bit on that edge, so the count stops one past (or at the cleared value after) the match. When it is 1, counting continues.
- R10: After reset, the counter is 0, the pins and pin states are 0, all outputs are disabled, and the flags are 0. All compare values are FFFFh, the start bit is 0, and all actions are hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| cnt_en | input | 1 | Count-source enable |
| cnt_value | output | 16 | Current counter value |
| pin_out | output | 3 | Channel pins A (bit 0), B, C |
| match_flag | output | 3 | Sticky match flags A, B, C |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
All four action codes are tried with both initial levels. A design that decoded the codes wrongly would show the wrong pin level one edge after the match. A sequence with three channels, cleared by channel A, checks that the clear lands on 0000h rather than one past the compare value, and that toggling repeats each period. The clear from FFFFh and the natural wrap must both raise overflow; a design that signalled only one of them would leave the flag low. Same-cycle collisions are driven on purpose: a flag clear against a match, an initial-level load against a match, and a counter load against counting. A design with the wrong priority would clear a flag it should keep, apply an action it should drop, or miss the loaded value.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pin_act_e;

  // Pin level after a match, given the programmed action and the present level.
  function automatic logic apply_action(input pin_act_e act, input logic cur);
    case (act)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  // Counter value after a counting edge.
  function automatic logic [15:0] step_count(input logic [15:0] cur, input logic clear);
    return clear ? 16'h0000 : cur + 16'h0001;
  endfunction

endpackage

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clear_hit,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          wrap_evt
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  // Leaving the all-ones value by any counting edge is an overflow.
  assign wrap_evt = step && !load && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (step)      cnt <= clear_hit ? '0 : cnt + CW'(1);
  end
endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel
  import cmp_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] cnt,
  input  logic          cmp_wr,
  input  logic [CW-1:0] wr_data,
  input  pin_act_e      act,
  input  logic          init_load,
  input  logic          init_lvl,
  output logic          match,
  output logic          pin_state
);
  logic [CW-1:0] cmp_val;

  assign match = step && (cnt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_val <= '1;
    else if (cmp_wr) cmp_val <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pin_state <= 1'b0;
    else if (init_load) pin_state <= init_lvl;
    else if (match)     pin_state <= apply_action(act, pin_state);
  end
endmodule

// File: rtl/cmp_timer3.sv
module cmp_timer3
  import cmp_timer_pkg::*;
#(
  parameter int CW  = 16,
  parameter int NCH = 3,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic           cnt_en,
  output logic [CW-1:0]  cnt_value,
  output logic [NCH-1:0] pin_out,
  output logic [NCH-1:0] match_flag,
  output logic           ovf_flag
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_OUT  = AW'(1);
  localparam logic [AW-1:0] A_ACT  = AW'(2);
  localparam logic [AW-1:0] A_FLAG = AW'(3);
  localparam int            A_CMP0 = 4;
  localparam logic [AW-1:0] A_CNT  = AW'(A_CMP0 + NCH);
  localparam logic [2:0]    CLR_ON_A = 3'b001;

  logic             run, keep;
  logic [2:0]       clr_sel;
  logic [NCH-1:0]   init_lvl, oe_n, pin_state, match_vec;
  logic [2*NCH-1:0] act_cfg;
  logic             ctrl_wr, out_wr, act_wr, flag_wr, cnt_wr;
  logic             step, clear_hit, stop_evt, wrap_evt;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign out_wr  = wr_en && (wr_addr == A_OUT);
  assign act_wr  = wr_en && (wr_addr == A_ACT);
  assign flag_wr = wr_en && (wr_addr == A_FLAG);
  assign cnt_wr  = wr_en && (wr_addr == A_CNT);

  assign step      = run && cnt_en;
  assign clear_hit = (clr_sel == CLR_ON_A) && match_vec[0];
  assign stop_evt  = !keep && match_vec[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; keep <= 1'b0; clr_sel <= '0;
    end else if (ctrl_wr) begin
      run <= wr_data[0]; keep <= wr_data[1]; clr_sel <= wr_data[4:2];
    end else if (stop_evt) begin
      run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_lvl <= '0; oe_n <= '1; act_cfg <= '0;
    end else begin
      if (out_wr) begin
        init_lvl <= wr_data[NCH-1:0];
        oe_n     <= wr_data[2*NCH-1:NCH];
      end
      if (act_wr) act_cfg <= wr_data[2*NCH-1:0];
    end
  end

  // Sticky flags: a write can only clear, a same-cycle event re-sets.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_flag <= '0; ovf_flag <= 1'b0;
    end else begin
      match_flag <= (flag_wr ? (match_flag & wr_data[NCH-1:0]) : match_flag) | match_vec;
      ovf_flag   <= (flag_wr ? (ovf_flag & wr_data[NCH]) : ovf_flag) | wrap_evt;
    end
  end

  cmp_timer_counter #(.CW(CW)) u_counter (
    .clk, .rst_n, .step, .clear_hit,
    .load(cnt_wr), .load_val(wr_data), .cnt(cnt_value), .wrap_evt
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cmp_timer_channel #(.CW(CW)) u_ch (
      .clk, .rst_n, .step, .cnt(cnt_value),
      .cmp_wr(wr_en && (wr_addr == AW'(A_CMP0 + i))),
      .wr_data,
      .act(pin_act_e'(act_cfg[2*i +: 2])),
      .init_load(out_wr), .init_lvl(wr_data[i]),
      .match(match_vec[i]), .pin_state(pin_state[i])
    );
  end

  assign pin_out = pin_state & ~oe_n;
endmodule

// File: rtl/cmp_timer_checker.sv
module cmp_timer_checker #(
  parameter int CW  = 16,
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           step,
  input logic           cnt_wr,
  input logic           ctrl_wr,
  input logic [CW-1:0]  cnt,
  input logic [2:0]     clr_sel,
  input logic           keep,
  input logic           run,
  input logic [NCH-1:0] match_vec,
  input logic [NCH-1:0] match_flag,
  input logic           wrap_evt,
  input logic           ovf_flag,
  input logic [NCH-1:0] pin_out,
  input logic [NCH-1:0] oe_n
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !cnt_wr) |=> $stable(cnt)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_wr && !(clr_sel == 3'b001 && match_vec[0])) |=> (cnt == $past(cnt) + CW'(1))); // R1
  AST_CLEAR_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sel == 3'b001 && match_vec[0] && !cnt_wr) |=> (cnt == '0)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec != '0) |=> ((match_flag & $past(match_vec)) == $past(match_vec))); // R6
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag); // R8
  AST_STOP_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!keep && match_vec[0] && !ctrl_wr) |=> !run); // R9
  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & oe_n) == '0)); // R5
endmodule

bind cmp_timer3 cmp_timer_checker #(.CW(CW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .cnt_wr(cnt_wr), .ctrl_wr(ctrl_wr),
  .cnt(cnt_value), .clr_sel(clr_sel), .keep(keep), .run(run),
  .match_vec(match_vec), .match_flag(match_flag), .wrap_evt(wrap_evt),
  .ovf_flag(ovf_flag), .pin_out(pin_out), .oe_n(oe_n)
);

// File: tb/test_cmp_timer3.sv
module test_cmp_timer3;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cnt_en = 1'b0;
  logic [15:0] cnt_value;
  logic [2:0]  pin_out, match_flag;
  logic        ovf_flag;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmp_timer3 i_cmp_timer3 (.*);

  // {action[1:0], initial level, expected pin after one match}
  localparam logic [3:0] VEC [8] = '{
    4'b00_0_0, 4'b00_1_1, 4'b01_1_0, 4'b01_0_0,
    4'b10_0_1, 4'b10_1_1, 4'b11_0_1, 4'b11_1_0 };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic ce = 1'b0);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d; cnt_en = ce;
    @(posedge clk); #2 wr_en = 1'b0; cnt_en = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk); cnt_en = 1'b1;
      @(posedge clk); #2 cnt_en = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R10: reset state
    chk("R10 counter", cnt_value, 0);
    chk("R10 pins", pin_out, 0);
    chk("R10 flags", {ovf_flag, match_flag}, 0);

    // R3/R4: every action code on channel B with both initial levels
    for (int k = 0; k < 8; k++) begin
      wr(0, 16'h0000);
      wr(3, 16'h0000);
      wr(1, {15'd0, VEC[k][1]} << 1);
      wr(2, {14'd0, VEC[k][3:2]} << 2);
      wr(5, 16'd5);
      wr(7, 16'd3);
      chk("R4 initial level", pin_out[1], VEC[k][1]);
      wr(0, 16'h0003);
      tick(3);
      chk("R3 action result", pin_out[1], VEC[k][0]);
      chk("R6 flag B set", match_flag, 3'b010);
      chk("R1 count after 3 steps", cnt_value, 6);
    end

    // R3/R7: three channels, clear on A = 3 (A toggle, B high, C low)
    wr(0, 0); wr(3, 0);
    wr(4, 3); wr(5, 1); wr(6, 2);
    wr(2, 16'b01_10_11);
    wr(1, 16'b000_100);
    wr(7, 0);
    wr(0, 16'b001_1_1);
    tick(4);
    chk("R3 three channels period 1", pin_out, 3'b011);
    chk("R7 cleared to zero", cnt_value, 0);
    tick(4);
    chk("R3 toggle repeats", pin_out, 3'b010);

    // R7: clear on A at 4
    wr(0, 0); wr(3, 0); wr(4, 4); wr(7, 0);
    wr(0, 16'b001_1_1);
    tick(5);
    chk("R7 clear on A", cnt_value, 0);
    chk("R8 no overflow on clear", ovf_flag, 0);
    tick(2);
    chk("R7 resumes from zero", cnt_value, 2);

    // R8: clear from FFFFh behaves as overflow
    wr(0, 0); wr(3, 0); wr(4, 16'hFFFF); wr(7, 16'hFFFD);
    wr(0, 16'b001_1_1);
    tick(3);
    chk("R8 clear at FFFF counter", cnt_value, 0);
    chk("R8 clear at FFFF ovf", ovf_flag, 1);

    // R8: natural wrap, clear select off
    wr(0, 0); wr(3, 0); wr(4, 16'h1234); wr(7, 16'hFFFE);
    wr(0, 16'b000_1_1);
    tick(2);
    chk("R8 wrap counter", cnt_value, 0);
    chk("R8 wrap ovf", ovf_flag, 1);
    wr(3, 16'h0007);
    chk("R8 ovf cleared by 0", ovf_flag, 0);

    // R9: stop on A match
    wr(0, 0); wr(4, 2); wr(7, 0);
    wr(0, 16'b000_0_1);
    tick(5);
    chk("R9 stopped after match", cnt_value, 3);

    // R1: no count with start bit 0, nor with cnt_en 0
    wr(0, 0); wr(7, 10);
    tick(4);
    chk("R1 hold when stopped", cnt_value, 10);
    wr(0, 16'b000_1_1);
    repeat (4) @(posedge clk);
    #2 chk("R1 hold without enable", cnt_value, 10);

    // R2: counter load wins over counting
    wr(7, 100, 1'b1);
    chk("R2 load priority", cnt_value, 100);

    // R5: active-low enables
    wr(0, 0);
    wr(1, (16'd7 << 3) | 16'd7);
    chk("R5 all disabled", pin_out, 3'b000);
    wr(1, (16'd2 << 3) | 16'd7);
    chk("R5 B disabled only", pin_out, 3'b101);

    // R6: match wins over a clearing write; then clear; write 1 no effect
    wr(1, 0);
    wr(4, 16'h1234); wr(5, 16'h1234); wr(6, 20); wr(7, 20);
    wr(3, 0);
    wr(0, 16'b000_1_1);
    wr(3, 0, 1'b1);
    chk("R6 match beats clear", match_flag, 3'b100);
    wr(3, 0);
    chk("R6 cleared by 0", match_flag, 3'b000);
    wr(3, 16'h000F);
    chk("R6 write 1 no effect", {ovf_flag, match_flag}, 0);

    // R4: initial-level write beats a same-cycle low action on C
    wr(0, 0); wr(2, 16'b01_00_00); wr(6, 30); wr(7, 30);
    wr(1, 16'b000_000);
    wr(0, 16'b000_1_1);
    wr(1, 16'b000_100, 1'b1);
    chk("R4 load beats match", pin_out[2], 1);
    chk("R6 flag C on collision", match_flag[2], 1);

    finish_run();
  end
endmodule